// File: doc/BRIEF.md
# Timer Output-Compare Channel

This block is one compare channel of a general-purpose up/down timer. An external counter supplies its current value, its count direction and an update-event pulse. The channel compares the counter against an active compare register and produces an active-high reference waveform and a one-cycle match flag. The mode field selects one of eight reference behaviours. These are hold, set, clear or toggle on a match, two static force levels, and two complementary PWM shapes.

Software-side writes arrive on two strobed ports. One carries the compare value. The other carries an 8-bit control word laid out as `{dir[1:0], clr_en, fast_en, pre_en, mode[2:0]}` from bit 7 down to bit 0. The compare value can go straight to the active register, or it can be staged in a shadow register that is copied over on each update event. An external clear input can pull the reference low at once. An optional fast path treats a rising trigger edge as a compare match in PWM modes. A lock input and the channel-enable bit protect selected control fields from writes.

Top module: `oc_channel`

## Requirements
- R1: While reset is asserted, `oc_ref` and `cmp_match` are 0. After reset the mode is hold (0), all enables are 0, and both compare registers hold 0, so `cmp_match` rises after the first edge that sees `cnt_val` equal to 0.
- R2: `cmp_match` is high for the cycle after each clock edge at which `cnt_val` equals the active compare value, in every mode including hold. It is low otherwise.
- R3: In hold mode (mode 0) the reference keeps its value whatever the counter does.
- R4: On a match edge, mode 1 sets the reference to 1, mode 2 clears it to 0 and mode 3 inverts it. Between matches these modes leave it unchanged.
- R5: Mode 4 drives the reference to 0 and mode 5 drives it to 1, from the edge after the mode is written.
- R6: In PWM-A (mode 6) the reference follows the counter one edge later. Counting up (`cnt_down`=0) it is 1 when `cnt_val < compare`. Counting down it is 0 when `cnt_val > compare` and 1 otherwise. PWM-B (mode 7) is the inverse of PWM-A in both directions.
- R7: In modes 6 and 7 the reference only moves when the PWM-A comparison result differs from the one seen at the previous edge, or on the first edge after the mode changes from hold to a PWM mode. Entering PWM from any other mode keeps the old level until the comparison result changes.
- R8: With `pre_en` (control bit 3) at 0, a compare write reaches the active register at the write edge. With `pre_en` at 1, writes go to the shadow register only, and the shadow is copied into the active register at each edge where `upd_evt` is 1.
- R9: With `clr_en` (control bit 5) at 1, `oc_ref` is 0 in the same cycle that `clr_in` is high, and the stored reference is cleared at the next edge. With `clr_en` at 0, `clr_in` has no effect.
- R10: With `fast_en` (control bit 4) at 1 in mode 6 or 7, a rising edge of `trig_in` sets the reference to the level the PWM mode gives when the counter sits on the compare value. That level is 0 for PWM-A counting up and 1 for PWM-A counting down, and PWM-B gives the inverse. The change appears at the third edge, counting the edge that first samples `trig_in` high. With `fast_en` at 0, or in any other mode, the trigger has no effect.
- R11: The direction field (control bits 7:6) is not changed by a control write while `chan_en` is 1. Any nonzero direction makes the channel an input and holds `oc_ref` at 0.
- R12: While `lock3` is 1 and the direction field is 0, control writes leave the mode field and `pre_en` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cnt_val | input | CNT_W | Current counter value |
| cnt_down | input | 1 | Count direction, 1 = down |
| upd_evt | input | 1 | Update-event pulse, loads shadow into active compare |
| cmp_wr | input | 1 | Compare value write strobe |
| cmp_wdata | input | CNT_W | Compare value write data |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | 8 | Control word `{dir[1:0], clr_en, fast_en, pre_en, mode[2:0]}` |
| chan_en | input | 1 | Channel enable, freezes the direction field |
| lock3 | input | 1 | Highest lock level, freezes mode and preload enable |
| clr_in | input | 1 | External reference clear |
| trig_in | input | 1 | Trigger input, rising edge is active |
| oc_ref | output | 1 | Active-high reference output |
| cmp_match | output | 1 | One-cycle compare match flag |

## Verification
The reference and the match flag are registered, so for a counter value driven before an edge both are due right after that same edge. Control and compare writes take one edge to land, so a mode's effect is due one edge after its write edge. Only the clear gating acts within the cycle, and it is checked a moment after `clr_in` changes, before the next edge. The fast trigger is checked at each of the three edges after the trigger rises: unchanged after the first two, at the new level after the third. Inputs change on the falling clock edge and outputs are sampled on it. This keeps every expected value tied to a known edge count.

// File: rtl/oc_pkg.sv
package oc_pkg;

    localparam int CTL_W = 8;

    typedef enum logic [2:0] {
        OCM_HOLD  = 3'd0,
        OCM_SET   = 3'd1,
        OCM_CLR   = 3'd2,
        OCM_TOG   = 3'd3,
        OCM_LOW   = 3'd4,
        OCM_HIGH  = 3'd5,
        OCM_PWMA  = 3'd6,
        OCM_PWMB  = 3'd7
    } oc_mode_e;

    // bit 7..6 dir, 5 clr_en, 4 fast_en, 3 pre_en, 2..0 mode
    typedef struct packed {
        logic [1:0] dir;
        logic       clr_en;
        logic       fast_en;
        logic       pre_en;
        oc_mode_e   mode;
    } oc_ctl_t;

    function automatic logic is_pwm(input oc_mode_e m);
        return (m == OCM_PWMA) || (m == OCM_PWMB);
    endfunction

endpackage

// File: rtl/oc_regs.sv
module oc_regs
    import oc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ctl_wr,
    input  logic [CTL_W-1:0]    ctl_wdata,
    input  logic                cmp_wr,
    input  logic [CNT_W-1:0]    cmp_wdata,
    input  logic                chan_en,
    input  logic                lock3,
    input  logic                upd_evt,
    output oc_ctl_t             ctl,
    output logic [CNT_W-1:0]    ccr_act
);

    typedef struct packed {
        oc_ctl_t          ctl;
        logic [CNT_W-1:0] shadow;
        logic [CNT_W-1:0] act;
    } regs_t;

    regs_t   q, d;
    oc_ctl_t wr_word;

    assign wr_word = oc_ctl_t'(ctl_wdata);

    always_comb begin
        d = q;
        if (ctl_wr) begin
            d.ctl.clr_en  = wr_word.clr_en;
            d.ctl.fast_en = wr_word.fast_en;
            if (!(lock3 && (q.ctl.dir == 2'd0))) begin
                d.ctl.mode   = wr_word.mode;
                d.ctl.pre_en = wr_word.pre_en;
            end
            if (!chan_en) begin
                d.ctl.dir = wr_word.dir;
            end
        end
        if (cmp_wr) begin
            d.shadow = cmp_wdata;
            if (!q.ctl.pre_en) begin
                d.act = cmp_wdata;
            end
        end
        if (q.ctl.pre_en && upd_evt) begin
            d.act = q.shadow;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign ctl     = q.ctl;
    assign ccr_act = q.act;

    p_dir_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && chan_en) |=> $stable(q.ctl.dir));

    p_lock_mode_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && lock3 && (q.ctl.dir == 2'd0)) |=> ($stable(q.ctl.mode) && $stable(q.ctl.pre_en)));

    p_shadow_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ctl.pre_en && !upd_evt) |=> $stable(q.act));

    p_direct_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_wr && !q.ctl.pre_en) |=> (q.act == $past(cmp_wdata)));

endmodule

// File: rtl/oc_trig.sv
module oc_trig (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_in,
    output logic trig_hit
);

    typedef struct packed {
        logic s1;
        logic s2;
        logic hit;
    } trig_t;

    trig_t q, d;

    always_comb begin
        d.s1  = trig_in;
        d.s2  = q.s1;
        d.hit = q.s1 & ~q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign trig_hit = q.hit;

    p_single_hit_r10: assert property (@(posedge clk) disable iff (!rst_n)
        q.hit |=> !q.hit);

endmodule

// File: rtl/oc_ref_gen.sv
module oc_ref_gen
    import oc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic             cnt_down,
    input  logic [CNT_W-1:0] ccr,
    input  oc_ctl_t          ctl,
    input  logic             trig_hit,
    input  logic             clr_in,
    output logic             oc_ref,
    output logic             cmp_match
);

    typedef struct packed {
        logic ref_lvl;
        logic raw;
        logic was_hold;
        logic match;
    } gen_t;

    gen_t q, d;
    logic eq, raw, pwm_lvl, trig_lvl, is_out, clear_now, fast_fire;

    always_comb begin
        eq        = (cnt_val == ccr);
        raw       = cnt_down ? !(cnt_val > ccr) : (cnt_val < ccr);
        pwm_lvl   = (ctl.mode == OCM_PWMB) ? !raw : raw;
        trig_lvl  = cnt_down ^ (ctl.mode == OCM_PWMB);
        is_out    = (ctl.dir == 2'd0);
        clear_now = ctl.clr_en & clr_in;
        fast_fire = ctl.fast_en & trig_hit & is_pwm(ctl.mode);

        d.match    = eq;
        d.raw      = raw;
        d.was_hold = (ctl.mode == OCM_HOLD);
        d.ref_lvl  = q.ref_lvl;
        case (ctl.mode)
            OCM_HOLD: d.ref_lvl = q.ref_lvl;
            OCM_SET:  if (eq) d.ref_lvl = 1'b1;
            OCM_CLR:  if (eq) d.ref_lvl = 1'b0;
            OCM_TOG:  if (eq) d.ref_lvl = ~q.ref_lvl;
            OCM_LOW:  d.ref_lvl = 1'b0;
            OCM_HIGH: d.ref_lvl = 1'b1;
            OCM_PWMA, OCM_PWMB: begin
                if (fast_fire)                          d.ref_lvl = trig_lvl;
                else if ((raw != q.raw) || q.was_hold)  d.ref_lvl = pwm_lvl;
            end
        endcase
        if (clear_now) d.ref_lvl = 1'b0;
        if (!is_out)   d.ref_lvl = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign oc_ref    = q.ref_lvl & is_out & ~clear_now;
    assign cmp_match = q.match;

    p_match_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_val == ccr) |=> cmp_match);

    p_hold_keeps_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((ctl.mode == OCM_HOLD) && is_out && !clear_now) |=> $stable(q.ref_lvl));

    p_force_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((ctl.mode == OCM_HIGH) && is_out && !clear_now) |=> q.ref_lvl);

    p_clear_sticks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clear_now |=> !q.ref_lvl);

    p_pwm_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (is_pwm(ctl.mode) && is_out && !clear_now && !fast_fire && (raw == q.raw) && !q.was_hold)
        |=> $stable(q.ref_lvl));

    p_input_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !is_out |=> !q.ref_lvl);

endmodule

// File: rtl/oc_channel.sv
module oc_channel
    import oc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic             cnt_down,
    input  logic             upd_evt,
    input  logic             cmp_wr,
    input  logic [CNT_W-1:0] cmp_wdata,
    input  logic             ctl_wr,
    input  logic [7:0]       ctl_wdata,
    input  logic             chan_en,
    input  logic             lock3,
    input  logic             clr_in,
    input  logic             trig_in,
    output logic             oc_ref,
    output logic             cmp_match
);

    oc_ctl_t          ctl;
    logic [CNT_W-1:0] ccr_act;
    logic             trig_hit;

    oc_regs #(.CNT_W(CNT_W)) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_wr    (ctl_wr),
        .ctl_wdata (ctl_wdata),
        .cmp_wr    (cmp_wr),
        .cmp_wdata (cmp_wdata),
        .chan_en   (chan_en),
        .lock3     (lock3),
        .upd_evt   (upd_evt),
        .ctl       (ctl),
        .ccr_act   (ccr_act)
    );

    oc_trig i_trig (
        .clk      (clk),
        .rst_n    (rst_n),
        .trig_in  (trig_in),
        .trig_hit (trig_hit)
    );

    oc_ref_gen #(.CNT_W(CNT_W)) i_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .cnt_val   (cnt_val),
        .cnt_down  (cnt_down),
        .ccr       (ccr_act),
        .ctl       (ctl),
        .trig_hit  (trig_hit),
        .clr_in    (clr_in),
        .oc_ref    (oc_ref),
        .cmp_match (cmp_match)
    );

    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |-> (!oc_ref && !cmp_match));

endmodule

// File: tb/test_oc_channel.sv
module test_oc_channel;

    localparam int CLK_PERIOD = 10;
    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] cnt_val = '0;
    logic         cnt_down = 1'b0;
    logic         upd_evt = 1'b0;
    logic         cmp_wr = 1'b0;
    logic [W-1:0] cmp_wdata = '0;
    logic         ctl_wr = 1'b0;
    logic [7:0]   ctl_wdata = '0;
    logic         chan_en = 1'b0;
    logic         lock3 = 1'b0;
    logic         clr_in = 1'b0;
    logic         trig_in = 1'b0;
    logic         oc_ref;
    logic         cmp_match;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    oc_channel #(.CNT_W(W)) i_oc_channel (
        .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .cnt_down(cnt_down),
        .upd_evt(upd_evt), .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata),
        .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .chan_en(chan_en),
        .lock3(lock3), .clr_in(clr_in), .trig_in(trig_in),
        .oc_ref(oc_ref), .cmp_match(cmp_match)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [7:0] cw(input logic [1:0] dir, input logic clr,
                                      input logic fast, input logic pre, input logic [2:0] m);
        return {dir, clr, fast, pre, m};
    endfunction

    task automatic wr_ctl(input logic [7:0] v);
        ctl_wr = 1'b1; ctl_wdata = v;
        tick();
        ctl_wr = 1'b0;
    endtask

    task automatic wr_cmp(input logic [W-1:0] v);
        cmp_wr = 1'b1; cmp_wdata = v;
        tick();
        cmp_wr = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic exp;
        // R1 reset state
        repeat (3) @(negedge clk);
        check("R1 ref in reset", oc_ref, 1'b0);
        check("R1 match in reset", cmp_match, 1'b0);
        rst_n = 1'b1;
        cnt_val = 4'd0;
        tick();
        check("R1 compare resets to 0", cmp_match, 1'b1);
        cnt_val = 4'd5;
        tick();
        check("R1 match drops", cmp_match, 1'b0);
        check("R1 ref after reset", oc_ref, 1'b0);

        // R2 R3 hold mode: match pulses, ref stays 0
        wr_cmp(4'd9);
        for (int c = 0; c < 16; c++) begin
            cnt_val = W'(c); tick();
            check("R2 match in hold", cmp_match, (c == 9));
            check("R3 hold keeps 0", oc_ref, 1'b0);
        end
        // R5 force high, then hold keeps 1
        wr_ctl(cw(2'd0, 1'b0, 1'b0, 1'b0, 3'd5));
        tick();
        check("R5 force high", oc_ref, 1'b1);
        wr_ctl(cw(2'd0, 1'b0, 1'b0, 1'b0, 3'd0));
        for (int c = 0; c < 16; c++) begin
            cnt_val = W'(c); tick();
            check("R3 hold keeps 1", oc_ref, 1'b1);
        end
        wr_ctl(cw(2'd0, 1'b0, 1'b0, 1'b0, 3'd4));
        tick();
        check("R5 force low", oc_ref, 1'b0);

        // R4 set on match
        cnt_val = 4'd0;
        wr_ctl(cw(2'd0, 1'b0, 1'b0, 1'b0, 3'd1));
        exp = 1'b0;
        for (int c = 0; c < 16; c++) begin
            cnt_val = W'(c); tick();
            exp = exp | (c == 9);
            check("R4 set on match", oc_ref, exp);
        end
        // R4 clear on match
        wr_ctl(cw(2'd0, 1'b0, 1'b0, 1'b0, 3'd5));
        cnt_val = 4'd0;
        wr_ctl(cw(2'd0, 1'b0, 1'b0, 1'b0, 3'd2));
        exp = 1'b1;
        for (int c = 0; c < 16; c++) begin
            cnt_val = W'(c); tick();
            if (c == 9) exp = 1'b0;
            check("R4 clear on match", oc_ref, exp);
        end
        // R4 toggle on match
        wr_ctl(cw(2'd0, 1'b0, 1'b0, 1'b0, 3'd4));
        cnt_val = 4'd0;
        wr_ctl(cw(2'd0, 1'b0, 1'b0, 1'b0, 3'd3));
        exp = 1'b0;
        for (int k = 0; k < 32; k++) begin
            cnt_val = W'(k % 16); tick();
            if ((k % 16) == 9) exp = ~exp;
            check("R4 toggle on match", oc_ref, exp);
        end

        // R6 PWM sweep: both modes, both directions, all compare values
        for (int m = 6; m < 8; m++) begin
            for (int dn = 0; dn < 2; dn++) begin
                for (int cc = 0; cc < 16; cc++) begin
                    wr_ctl(cw(2'd0, 1'b0, 1'b0, 1'b0, 3'd0));
                    wr_cmp(W'(cc));
                    cnt_down = dn[0];
                    cnt_val = (dn != 0) ? 4'd15 : 4'd0;
                    wr_ctl(cw(2'd0, 1'b0, 1'b0, 1'b0, m[2:0]));
                    for (int i = 0; i < 16; i++) begin
                        int c;
                        logic lvl;
                        c = (dn != 0) ? 15 - i : i;
                        cnt_val = W'(c); tick();
                        lvl = (dn != 0) ? !(c > cc) : (c < cc);
                        if (m == 7) lvl = !lvl;
                        check("R6 pwm level", oc_ref, lvl);
                        check("R2 match in pwm", cmp_match, (c == cc));
                    end
                end
            end
        end

        // R7 entry from a non-hold mode keeps level until compare changes
        cnt_down = 1'b0;
        wr_ctl(cw(2'd0, 1'b0, 1'b0, 1'b0, 3'd5));
        wr_cmp(4'd3);
        cnt_val = 4'd10;
        wr_ctl(cw(2'd0, 1'b0, 1'b0, 1'b0, 3'd6));
        tick();
        check("R7 keep level on entry", oc_ref, 1'b1);
        tick();
        check("R7 keep level", oc_ref, 1'b1);
        cnt_val = 4'd2; tick();
        check("R7 change to below", oc_ref, 1'b1);
        cnt_val = 4'd5; tick();
        check("R7 change to above", oc_ref, 1'b0);
        wr_ctl(cw(2'd0, 1'b0, 1'b0, 1'b0, 3'd0));
        wr_ctl(cw(2'd0, 1'b0, 1'b0, 1'b0, 3'd7));
        tick();
        check("R7 load on entry from hold", oc_ref, 1'b1);

        // R8 preload
        wr_ctl(cw(2'd0, 1'b0, 1'b0, 1'b1, 3'd0));
        wr_cmp(4'd12);
        cnt_val = 4'd3; tick();
        check("R8 active unchanged", cmp_match, 1'b1);
        cnt_val = 4'd12; tick();
        check("R8 shadow not active", cmp_match, 1'b0);
        upd_evt = 1'b1; tick(); upd_evt = 1'b0;
        cnt_val = 4'd12; tick();
        check("R8 copied on update", cmp_match, 1'b1);
        cnt_val = 4'd3; tick();
        check("R8 old value gone", cmp_match, 1'b0);
        wr_ctl(cw(2'd0, 1'b0, 1'b0, 1'b0, 3'd0));
        wr_cmp(4'd6);
        cnt_val = 4'd6; tick();
        check("R8 direct write", cmp_match, 1'b1);

        // R9 clear
        wr_ctl(cw(2'd0, 1'b1, 1'b0, 1'b0, 3'd5));
        tick();
        check("R9 high before clear", oc_ref, 1'b1);
        clr_in = 1'b1; #1;
        check("R9 immediate clear", oc_ref, 1'b0);
        tick();
        check("R9 held clear", oc_ref, 1'b0);
        clr_in = 1'b0; #1;
        check("R9 stored level cleared", oc_ref, 1'b0);
        tick();
        check("R9 released", oc_ref, 1'b1);
        wr_ctl(cw(2'd0, 1'b0, 1'b0, 1'b0, 3'd5));
        clr_in = 1'b1; #1;
        check("R9 clear ignored now", oc_ref, 1'b1);
        tick();
        check("R9 clear ignored next", oc_ref, 1'b1);
        clr_in = 1'b0;

        // R10 fast trigger, PWM-B counting up
        wr_ctl(cw(2'd0, 1'b0, 1'b0, 1'b0, 3'd0));
        wr_cmp(4'd8);
        cnt_val = 4'd2; cnt_down = 1'b0;
        wr_ctl(cw(2'd0, 1'b0, 1'b1, 1'b0, 3'd7));
        tick();
        check("R10 pwm-b start low", oc_ref, 1'b0);
        trig_in = 1'b1;
        tick(); check("R10 edge 1 no change", oc_ref, 1'b0);
        tick(); check("R10 edge 2 no change", oc_ref, 1'b0);
        tick(); check("R10 edge 3 forced", oc_ref, 1'b1);
        trig_in = 1'b0;
        repeat (3) tick();
        check("R10 forced level held", oc_ref, 1'b1);
        // R10 fast trigger, PWM-A counting down
        wr_ctl(cw(2'd0, 1'b0, 1'b0, 1'b0, 3'd0));
        cnt_val = 4'd12; cnt_down = 1'b1;
        wr_ctl(cw(2'd0, 1'b0, 1'b1, 1'b0, 3'd6));
        tick();
        check("R10 pwm-a down start low", oc_ref, 1'b0);
        trig_in = 1'b1;
        tick(); tick();
        check("R10 down edge 2 no change", oc_ref, 1'b0);
        tick();
        check("R10 down edge 3 forced", oc_ref, 1'b1);
        trig_in = 1'b0;
        repeat (2) tick();
        // R10 no fast enable
        wr_ctl(cw(2'd0, 1'b0, 1'b0, 1'b0, 3'd0));
        cnt_val = 4'd2; cnt_down = 1'b0;
        wr_ctl(cw(2'd0, 1'b0, 1'b0, 1'b0, 3'd7));
        tick();
        trig_in = 1'b1;
        repeat (4) tick();
        check("R10 trigger ignored without fast", oc_ref, 1'b0);
        trig_in = 1'b0;
        repeat (2) tick();
        // R10 fast in non-PWM mode
        wr_ctl(cw(2'd0, 1'b0, 1'b1, 1'b0, 3'd1));
        trig_in = 1'b1;
        repeat (4) tick();
        check("R10 trigger ignored outside pwm", oc_ref, 1'b0);
        trig_in = 1'b0;

        // R11 direction field
        chan_en = 1'b1;
        wr_ctl(cw(2'd2, 1'b0, 1'b0, 1'b0, 3'd5));
        tick();
        check("R11 dir write ignored when enabled", oc_ref, 1'b1);
        chan_en = 1'b0;
        wr_ctl(cw(2'd1, 1'b0, 1'b0, 1'b0, 3'd5));
        check("R11 input channel low", oc_ref, 1'b0);
        tick();
        check("R11 input channel stays low", oc_ref, 1'b0);
        wr_ctl(cw(2'd0, 1'b0, 1'b0, 1'b0, 3'd5));
        tick();
        check("R11 back to output", oc_ref, 1'b1);

        // R12 lock
        lock3 = 1'b1;
        wr_ctl(cw(2'd0, 1'b0, 1'b0, 1'b1, 3'd4));
        tick();
        check("R12 mode locked", oc_ref, 1'b1);
        wr_cmp(4'd4);
        cnt_val = 4'd4; tick();
        check("R12 preload locked off", cmp_match, 1'b1);
        lock3 = 1'b0;
        wr_ctl(cw(2'd0, 1'b0, 1'b0, 1'b0, 3'd4));
        tick();
        check("R12 unlocked write", oc_ref, 1'b0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule